// File: doc/BRIEF.md
# HDLC Transmit Byte Buffer with Message Tagging

This block sits between a host and the transmit engine of an HDLC controller. The host pushes payload bytes into a 64-entry first-in first-out store. The engine pulls them out one at a time as it serializes the frame. To close a frame, the host arms a one-shot end-of-message control bit before it writes the final byte. That byte is then stored with a tag, and the engine receives it together with a last flag.

When the engine asks for a byte, the block answers on the next cycle with exactly one of three responses. It hands out a byte. It tells the engine to send idle flags, because no message is in progress. Or it tells the engine to abort the frame, because the store ran dry before the tagged byte arrived. After an abort, the block discards the rest of the broken message on its own, up to and including the next tagged byte, so that the next request starts on a clean message boundary.

Status outputs show whether the store is empty or full, whether the last frame underran, and whether the end-of-message bit is armed. Single-cycle event pulses report the fill level falling to half, the store leaving the full state, a message completing, and an underrun. A host can use these to drive interrupt-based refilling.

Top module: `hdlc_tx_fifo`

## Requirements
- R1: While reset is held and on the first cycle after it, st_empty=1, st_full=0, st_underrun=0, eom_armed=0, and tx_valid, tx_idle, tx_abort and every ev_* output are 0.
- R2: Bytes reach the engine in the order they were written, one per request. A request sampled at a clock edge produces tx_valid=1 with tx_data on the cycle after that edge. st_empty is 1 exactly when 0 bytes are held, and st_full is 1 exactly when 64 bytes are held.
- R3: A write presented while st_full=1 is ignored: no byte is stored, and the sequence delivered afterwards is unchanged.
- R4: A pulse on eom_set arms the end-of-message bit (eom_armed=1). The next accepted write is tagged as last, and that write counts even when it arrives in the same cycle as eom_set. The bit then clears. A write rejected because the store is full leaves the bit armed.
- R5: A tagged byte is delivered with tx_last=1, and ev_msg_end pulses for one cycle in the same cycle. Untagged bytes carry tx_last=0.
- R6: A request made while the store is empty and no message is open is answered with tx_idle=1 (send flags). A message is open from the delivery of an untagged byte until a tagged byte is delivered or an underrun occurs.
- R7: A request made while the store is empty and a message is open is answered with tx_abort=1 and a one-cycle ev_underrun pulse. st_underrun goes to 1 and stays there until the next byte is delivered.
- R8: After an underrun, held bytes are discarded at one per cycle, up to and including the next tagged byte, and none of them is delivered. Requests made while discarding is in progress are answered with tx_idle=1.
- R9: ev_half_empty pulses for one cycle when the fill level drops from above 32 to 32 or below, in the first cycle the new level is in effect.
- R10: ev_not_full pulses for one cycle when the fill level drops from 64, in the first cycle the new level is in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| eom_set | input | 1 | Arms the end-of-message bit for the next accepted write |
| st_empty | output | 1 | Store holds no bytes |
| st_full | output | 1 | Store holds 64 bytes |
| st_underrun | output | 1 | Last frame aborted for lack of data |
| eom_armed | output | 1 | End-of-message bit waiting for a write |
| rd_req | input | 1 | Engine request for the next byte |
| tx_valid | output | 1 | tx_data carries a byte this cycle |
| tx_data | output | 8 | Byte for the serializer |
| tx_last | output | 1 | Delivered byte closes the message |
| tx_idle | output | 1 | Engine should send flags |
| tx_abort | output | 1 | Engine should abort the current frame |
| ev_half_empty | output | 1 | Fill level fell to half or below |
| ev_not_full | output | 1 | Store left the full state |
| ev_msg_end | output | 1 | Tagged byte delivered |
| ev_underrun | output | 1 | Store ran dry in mid-message |

## Verification
The hardest state to reach is an underrun followed by a discard that must stop exactly at the next tagged byte. This happens while the host is still writing the rest of the broken frame, and at the same time the engine keeps requesting and must get flags, not stale bytes. The bench first opens a message with a few untagged bytes and drains it one request too far. It then writes the tail of that frame, with its tag, followed immediately by a second complete message. The second message must come out intact, with no byte of the first. A long random phase then mixes writes, arming pulses and requests against a behavioural queue model, so underruns also occur while the store is nearly full. A directed fill to 64 entries also places a rejected write between an arming pulse and the next accepted write.

// File: rtl/hdlc_txf_pkg.sv
package hdlc_txf_pkg;

    localparam int unsigned DATA_W = 8;

    // One stored slot: payload byte plus the end-of-message tag.
    typedef struct packed {
        logic              last;
        logic [DATA_W-1:0] data;
    } txf_entry_t;

    localparam int unsigned ENTRY_W = $bits(txf_entry_t);

    // Control state of the transmit side, registered as a whole.
    typedef struct packed {
        logic              in_msg;
        logic              dropping;
        logic              underrun;
        logic              eom;
        logic              tx_valid;
        logic [DATA_W-1:0] tx_data;
        logic              tx_last;
        logic              tx_idle;
        logic              tx_abort;
        logic              msg_end;
        logic              urun_ev;
    } txf_ctl_t;

endpackage

// File: rtl/hdlc_txf_store.sv
module hdlc_txf_store
    import hdlc_txf_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  txf_entry_t                     push_entry,
    input  logic                           pop,
    output txf_entry_t                     head,
    output logic [$clog2(DEPTH+1)-1:0]     level
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [ENTRY_W-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.wr = (st_q.wr == LAST_IDX) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == LAST_IDX) ? '0 : st_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[st_q.wr] <= push_entry;
        end
    end

    assign head  = txf_entry_t'(mem[st_q.rd]);
    assign level = st_q.cnt;

    a_r3_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt < CNT_W'(DEPTH)));

    a_r2_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0));

    a_r2_level_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    a_r2_level_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

endmodule

// File: rtl/hdlc_txf_level_events.sv
module hdlc_txf_level_events #(
    parameter int unsigned DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       ev_half_empty,
    output logic                       ev_not_full
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] HALF_LVL = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    logic [CNT_W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    // Pulses appear in the first cycle the new level is visible.
    assign ev_half_empty = (prev_q > HALF_LVL) && (level <= HALF_LVL);
    assign ev_not_full   = (prev_q == FULL_LVL) && (level != FULL_LVL);

    a_r9_half_single: assert property (@(posedge clk) disable iff (!rst_n)
        ev_half_empty |=> !ev_half_empty);

    a_r10_not_full_single: assert property (@(posedge clk) disable iff (!rst_n)
        ev_not_full |=> !ev_not_full);

endmodule

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
    import hdlc_txf_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eom_set,
    output logic              st_empty,
    output logic              st_full,
    output logic              st_underrun,
    output logic              eom_armed,
    input  logic              rd_req,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_last,
    output logic              tx_idle,
    output logic              tx_abort,
    output logic              ev_half_empty,
    output logic              ev_not_full,
    output logic              ev_msg_end,
    output logic              ev_underrun
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    txf_ctl_t   ctl_d, ctl_q;
    txf_entry_t head;
    txf_entry_t push_entry;
    logic [CNT_W-1:0] level;
    logic is_empty, is_full;
    logic accept, tag, drop_pop, serve, pop;

    hdlc_txf_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (accept),
        .push_entry (push_entry),
        .pop        (pop),
        .head       (head),
        .level      (level)
    );

    hdlc_txf_level_events #(.DEPTH(DEPTH)) u_events (
        .clk           (clk),
        .rst_n         (rst_n),
        .level         (level),
        .ev_half_empty (ev_half_empty),
        .ev_not_full   (ev_not_full)
    );

    always_comb begin
        is_empty   = (level == '0);
        is_full    = (level == CNT_W'(DEPTH));
        accept     = wr_en && !is_full;
        tag        = ctl_q.eom || eom_set;
        push_entry = '{last: tag, data: wr_data};
        drop_pop   = ctl_q.dropping && !is_empty;
        serve      = rd_req && !ctl_q.dropping;
        pop        = drop_pop || (serve && !is_empty);

        ctl_d          = ctl_q;
        ctl_d.tx_valid = 1'b0;
        ctl_d.tx_data  = '0;
        ctl_d.tx_last  = 1'b0;
        ctl_d.tx_idle  = 1'b0;
        ctl_d.tx_abort = 1'b0;
        ctl_d.msg_end  = 1'b0;
        ctl_d.urun_ev  = 1'b0;

        // Discard phase after an abort: one slot per cycle until a tag.
        if (ctl_q.dropping) begin
            if (rd_req) begin
                ctl_d.tx_idle = 1'b1;
            end
            if (drop_pop && head.last) begin
                ctl_d.dropping = 1'b0;
            end
        end else if (serve) begin
            if (!is_empty) begin
                ctl_d.tx_valid = 1'b1;
                ctl_d.tx_data  = head.data;
                ctl_d.tx_last  = head.last;
                ctl_d.underrun = 1'b0;
                ctl_d.msg_end  = head.last;
                ctl_d.in_msg   = !head.last;
            end else if (ctl_q.in_msg) begin
                ctl_d.tx_abort = 1'b1;
                ctl_d.urun_ev  = 1'b1;
                ctl_d.underrun = 1'b1;
                ctl_d.in_msg   = 1'b0;
                ctl_d.dropping = 1'b1;
            end else begin
                ctl_d.tx_idle = 1'b1;
            end
        end

        // One-shot control bit: consumed by the next accepted write.
        ctl_d.eom = accept ? 1'b0 : tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign st_empty    = is_empty;
    assign st_full     = is_full;
    assign st_underrun = ctl_q.underrun;
    assign eom_armed   = ctl_q.eom;
    assign tx_valid    = ctl_q.tx_valid;
    assign tx_data     = ctl_q.tx_data;
    assign tx_last     = ctl_q.tx_last;
    assign tx_idle     = ctl_q.tx_idle;
    assign tx_abort    = ctl_q.tx_abort;
    assign ev_msg_end  = ctl_q.msg_end;
    assign ev_underrun = ctl_q.urun_ev;

    a_r6_single_response: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_valid, tx_idle, tx_abort}));

    a_r2_response_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req == 1'b0) |=> !(tx_valid || tx_idle || tx_abort));

    a_r5_end_with_last: assert property (@(posedge clk) disable iff (!rst_n)
        ev_msg_end |-> (tx_valid && tx_last));

    a_r7_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> (st_underrun && ev_underrun));

    a_r4_eom_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !st_full) |=> !eom_armed);

    a_r8_no_data_while_dropping: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.dropping |=> !tx_valid);

endmodule

// File: tb/hdlc_tx_fifo_bench.sv
module hdlc_tx_fifo_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       eom_set = 1'b0;
    logic       rd_req = 1'b0;
    logic       st_empty, st_full, st_underrun, eom_armed;
    logic       tx_valid, tx_last, tx_idle, tx_abort;
    logic [7:0] tx_data;
    logic       ev_half_empty, ev_not_full, ev_msg_end, ev_underrun;

    int errors = 0;
    int checks = 0;
    bit compare_on = 0;

    always #10 clk = ~clk;

    hdlc_tx_fifo u_hdlc_tx_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .eom_set(eom_set), .st_empty(st_empty), .st_full(st_full),
        .st_underrun(st_underrun), .eom_armed(eom_armed), .rd_req(rd_req),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_idle(tx_idle), .tx_abort(tx_abort), .ev_half_empty(ev_half_empty),
        .ev_not_full(ev_not_full), .ev_msg_end(ev_msg_end), .ev_underrun(ev_underrun)
    );

    // Behavioural reference model.
    bit [8:0] mq[$];
    bit m_in, m_drop, m_urun, m_eom;
    bit m_valid, m_last, m_idle, m_abort, m_mend, m_uev;
    bit [7:0] m_data;
    int m_prev;
    int m_sz;
    bit m_acc, m_tag;
    bit [8:0] m_h;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_in = 0; m_drop = 0; m_urun = 0; m_eom = 0;
            m_valid = 0; m_last = 0; m_idle = 0; m_abort = 0; m_mend = 0; m_uev = 0;
            m_data = 0; m_prev = 0;
        end else begin
            m_sz = mq.size();
            m_prev = m_sz;
            m_acc = wr_en && (m_sz < 64);
            m_tag = m_eom || eom_set;
            m_valid = 0; m_last = 0; m_idle = 0; m_abort = 0; m_mend = 0; m_uev = 0;
            if (m_drop) begin
                if (rd_req) m_idle = 1;
                if (m_sz > 0) begin
                    m_h = mq.pop_front();
                    if (m_h[8]) m_drop = 0;
                end
            end else if (rd_req) begin
                if (m_sz > 0) begin
                    m_h = mq.pop_front();
                    m_valid = 1; m_data = m_h[7:0]; m_last = m_h[8];
                    m_urun = 0; m_mend = m_h[8]; m_in = !m_h[8];
                end else if (m_in) begin
                    m_abort = 1; m_uev = 1; m_urun = 1; m_in = 0; m_drop = 1;
                end else begin
                    m_idle = 1;
                end
            end
            if (m_acc) mq.push_back({m_tag, wr_data});
            m_eom = m_acc ? 1'b0 : m_tag;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (compare_on) begin
            check("R2", "st_empty", st_empty, mq.size() == 0);
            check("R2", "st_full", st_full, mq.size() == 64);
            check("R4", "eom_armed", eom_armed, m_eom);
            check("R7", "st_underrun", st_underrun, m_urun);
            check("R7", "ev_underrun", ev_underrun, m_uev);
            check("R7", "tx_abort", tx_abort, m_abort);
            check("R2", "tx_valid", tx_valid, m_valid);
            if (m_valid) check("R2 R8", "tx_data", tx_data, m_data);
            check("R5", "tx_last", tx_last, m_last);
            check("R5", "ev_msg_end", ev_msg_end, m_mend);
            check("R6", "tx_idle", tx_idle, m_idle);
            check("R9", "ev_half_empty", ev_half_empty, (m_prev > 32) && (mq.size() <= 32));
            check("R10", "ev_not_full", ev_not_full, (m_prev == 64) && (mq.size() != 64));
        end
    end

    task automatic step(input bit w, input bit [7:0] d, input bit e, input bit r);
        @(negedge clk);
        wr_en = w; wr_data = d; eom_set = e; rd_req = r;
    endtask

    task automatic idle_step();
        step(0, 8'h00, 0, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held.
        check("R1", "st_empty in reset", st_empty, 1);
        check("R1", "st_full in reset", st_full, 0);
        check("R1", "outputs in reset", {tx_valid, tx_idle, tx_abort, ev_msg_end, ev_underrun, st_underrun, eom_armed}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "st_empty after reset", st_empty, 1);
        compare_on = 1;

        // R6: request with nothing queued and no message open gives flags.
        step(0, 0, 0, 1); idle_step();
        check("R6", "idle flag", tx_idle, 1);

        // R2 R5: five-byte message, last one tagged.
        for (int i = 0; i < 5; i++) step(1, 8'h10 + 8'(i), i == 4, 0);
        idle_step();
        for (int i = 0; i < 5; i++) begin
            step(0, 0, 0, 1); idle_step();
            check("R2", "ordered byte", tx_data, 8'h10 + i);
            check("R5", "last tag", tx_last, i == 4);
        end
        step(0, 0, 0, 1); idle_step();
        check("R6", "flags after message", tx_idle, 1);

        // R7 R8: underrun in mid-message, then discard up to the tag.
        for (int i = 0; i < 3; i++) step(1, 8'h20 + 8'(i), 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1);
        step(0, 0, 0, 1); idle_step();
        check("R7", "abort on dry store", tx_abort, 1);
        check("R7", "underrun status", st_underrun, 1);
        step(1, 8'h23, 0, 1);
        step(1, 8'h24, 1, 1);
        step(1, 8'h30, 0, 1);
        step(1, 8'h31, 1, 0);
        repeat (4) idle_step();
        step(0, 0, 0, 1); idle_step();
        check("R8", "first byte after discard", tx_data, 8'h30);
        check("R7", "underrun cleared", st_underrun, 0);
        step(0, 0, 0, 1); idle_step();
        check("R8", "second byte after discard", tx_data, 8'h31);

        // R3 R4 R9 R10: fill to full, rejected write, drain.
        for (int i = 0; i < 64; i++) step(1, 8'(i + 64), i == 63, 0);
        step(1, 8'hEE, 1, 0);
        idle_step();
        check("R2", "full at 64", st_full, 1);
        check("R4", "armed after rejected write", eom_armed, 1);
        step(0, 0, 0, 1); idle_step();
        check("R10", "not-full pulse", ev_not_full, 1);
        check("R3", "first byte not the rejected one", tx_data, 8'd64);
        for (int i = 0; i < 63; i++) step(0, 0, 0, 1);
        idle_step();
        check("R3", "last of full run", tx_data, 8'd127);
        check("R2", "empty after drain", st_empty, 1);
        step(1, 8'h5A, 0, 0); idle_step();
        step(0, 0, 0, 1); idle_step();
        check("R4", "carried tag", tx_last, 1);

        // R4: arming and write in the same cycle.
        step(1, 8'h77, 1, 0); idle_step();
        check("R4", "same-cycle disarm", eom_armed, 0);
        step(0, 0, 0, 1); idle_step();
        check("R4", "same-cycle tag", tx_last, 1);

        // Random mix against the model.
        for (int i = 0; i < 6000; i++) begin
            step(($urandom % 3) != 0, 8'($urandom), ($urandom % 10) == 0, ($urandom % 2) == 0);
        end
        for (int i = 0; i < 80; i++) step(0, 0, 0, 1);
        step(1, 8'h01, 1, 0);
        for (int i = 0; i < 80; i++) step(0, 0, 0, 1);
        idle_step();
        idle_step();
        finish_run();
    end

endmodule